// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Signed Compare

This block is a purely combinational arithmetic logic unit for two operands of a parameterised width (32 bits by default). It is built as a chain of identical one-bit cells. Each cell can complement either of its two operand bits. It then picks one of four values as its result bit: the AND of the two bits, their OR, the full-adder sum, or a "less" input. Carries ripple from each cell into the cell above it.

The carry into the lowest cell is the B-complement control, so subtraction needs no separate pin. Setting that control together with the add code gives a minus b. The top cell also reports signed overflow and a "set" bit. That bit is routed back to the less input of the lowest cell, while every other cell sees a constant 0 there. The less code therefore gives a signed set-less-than result. A zero flag covers all result bits. A datapath drives the three control fields from its decoded instruction and takes the four outputs in the same cycle.

Top module: `alu_bitslice`

## Requirements
- R1: With op = 0 (inv_a = 0, inv_b = 0), result is the bitwise AND of a and b.
- R2: With op = 1 (inv_a = 0, inv_b = 0), result is the bitwise OR of a and b.
- R3: With op = 2 and inv_b = 0, result is (a + b) mod 2^W and carry_out is bit W of the full sum. The carry into bit 0 is inv_b, here 0.
- R4: With op = 2 and inv_b = 1, result is (a - b) mod 2^W and carry_out is 1 exactly when a >= b as unsigned numbers.
- R5: inv_a = 1 replaces a by its complement in every operation, and inv_b = 1 does the same for b. The control {inv_a, inv_b, op} = 4'b1100 therefore gives the bitwise NOR of a and b.
- R6: With op = 3 and inv_b = 1, result bit 0 is 1 exactly when a < b as signed two's-complement numbers, even when a - b overflows. Result bits W-1..1 are 0.
- R7: For every code, overflow is 1 exactly when the chain's sum of the effective operands plus inv_b overflows as a signed value. That happens when the two effective operands have the same sign and the sum's top bit differs from it.
- R8: zero is 1 exactly when every result bit is 0, for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | W | First operand |
| b | input | W | Second operand |
| inv_a | input | 1 | Use the complement of a in every cell |
| inv_b | input | 1 | Use the complement of b in every cell; also the carry into bit 0 |
| op | input | 2 | Result select: 0 AND, 1 OR, 2 sum, 3 less |
| result | output | W | Result word |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow of the carry chain |
| carry_out | output | 1 | Carry out of the top cell |

## Verification
The hardest case to reach is set-less-than when the subtraction overflows. The sign of the difference is then wrong, and only the overflow correction in the top cell gives the right answer. Random operands seldom produce this with a visible effect. The stimulus therefore pairs the extreme values 0x80000000, 0x7FFFFFFF, 0 and all-ones against each other under every control code. The carry chain is driven through its full length by adding all-ones to 1 and by subtracting equal operands, which must give a zero result.

// File: rtl/alu_bitslice_pkg.sv
package alu_bitslice_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_SUM  = 2'd2,
        OP_LESS = 2'd3
    } alu_op_e;

    // Internal values of one bit cell
    typedef struct packed {
        logic a_eff;
        logic b_eff;
        logic sum;
        logic carry;
    } cell_calc_t;

    function automatic cell_calc_t cell_arith(input logic a, input logic b,
                                              input logic inv_a, input logic inv_b,
                                              input logic carry_in);
        cell_calc_t c;
        c.a_eff = a ^ inv_a;
        c.b_eff = b ^ inv_b;
        c.sum   = c.a_eff ^ c.b_eff ^ carry_in;
        c.carry = (c.a_eff & c.b_eff) | (carry_in & (c.a_eff ^ c.b_eff));
        return c;
    endfunction

    function automatic logic cell_select(input logic [1:0] op, input cell_calc_t c,
                                         input logic less);
        logic r;
        case (alu_op_e'(op))
            OP_AND:  r = c.a_eff & c.b_eff;
            OP_OR:   r = c.a_eff | c.b_eff;
            OP_SUM:  r = c.sum;
            default: r = less;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_cell.sv
module alu_cell
    import alu_bitslice_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_a_i,
    input  logic       inv_b_i,
    input  logic       carry_i,
    input  logic       less_i,
    input  logic [1:0] op_i,
    output logic       res_o,
    output logic       carry_o
);
    cell_calc_t calc_d;

    always_comb begin
        calc_d  = cell_arith(a_i, b_i, inv_a_i, inv_b_i, carry_i);
        res_o   = cell_select(op_i, calc_d, less_i);
        carry_o = calc_d.carry;
    end
endmodule

// File: rtl/alu_top_cell.sv
module alu_top_cell
    import alu_bitslice_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_a_i,
    input  logic       inv_b_i,
    input  logic       carry_i,
    input  logic       less_i,
    input  logic [1:0] op_i,
    output logic       res_o,
    output logic       carry_o,
    output logic       set_o,
    output logic       ovf_o
);
    cell_calc_t calc_d;
    logic       ovf_d;

    always_comb begin
        calc_d  = cell_arith(a_i, b_i, inv_a_i, inv_b_i, carry_i);
        // signed overflow: carry into the sign cell differs from carry out
        ovf_d   = carry_i ^ calc_d.carry;
        res_o   = cell_select(op_i, calc_d, less_i);
        carry_o = calc_d.carry;
        ovf_o   = ovf_d;
        // true sign of the difference, corrected when it overflows
        set_o   = calc_d.sum ^ ovf_d;
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int W     = 32,
    parameter int GROUP = 4
) (
    input  logic [W-1:0] word_i,
    output logic         zero_o
);
    localparam int NGRP = (W + GROUP - 1) / GROUP;
    localparam int WPAD = NGRP * GROUP;

    logic [WPAD-1:0] padded_d;
    logic [NGRP-1:0] grp_any_d;

    always_comb begin
        padded_d        = '0;
        padded_d[W-1:0] = word_i;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_any_d[g] = |padded_d[g*GROUP +: GROUP];
    end

    assign zero_o = ~|grp_any_d;
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inv_a,
    input  logic         inv_b,
    input  logic [1:0]   op,
    output logic [W-1:0] result,
    output logic         zero,
    output logic         overflow,
    output logic         carry_out
);
    localparam int MSB = W - 1;

    logic [W:0]   carry_w;
    logic [W-1:0] less_w;
    logic         set_w;

    assign carry_w[0] = inv_b;   // subtract and compare need carry-in 1

    always_comb begin
        less_w    = '0;
        less_w[0] = set_w;
    end

    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i == MSB) begin : g_top
            alu_top_cell u_cell (
                .a_i     (a[i]),
                .b_i     (b[i]),
                .inv_a_i (inv_a),
                .inv_b_i (inv_b),
                .carry_i (carry_w[i]),
                .less_i  (less_w[i]),
                .op_i    (op),
                .res_o   (result[i]),
                .carry_o (carry_w[i+1]),
                .set_o   (set_w),
                .ovf_o   (overflow)
            );
        end else begin : g_low
            alu_cell u_cell (
                .a_i     (a[i]),
                .b_i     (b[i]),
                .inv_a_i (inv_a),
                .inv_b_i (inv_b),
                .carry_i (carry_w[i]),
                .less_i  (less_w[i]),
                .op_i    (op),
                .res_o   (result[i]),
                .carry_o (carry_w[i+1])
            );
        end
    end

    assign carry_out = carry_w[W];

    alu_zero_detect #(.W(W)) u_zero (
        .word_i (result),
        .zero_o (zero)
    );
endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         inv_a,
    input logic         inv_b,
    input logic [1:0]   op,
    input logic [W-1:0] result,
    input logic         zero,
    input logic         overflow,
    input logic         carry_out
);
    logic [W-1:0] ea, eb;
    logic [W:0]   full;

    always_comb begin
        ea   = inv_a ? ~a : a;
        eb   = inv_b ? ~b : b;
        full = {1'b0, ea} + {1'b0, eb} + {{W{1'b0}}, inv_b};
        if (!$isunknown({a, b, inv_a, inv_b, op, result, zero, overflow, carry_out})) begin
            AST_ZERO_FLAG: assert (zero == (result == '0));                         // R8
            AST_LOGIC_AND: assert (op != 2'd0 || result == (ea & eb));              // R1
            AST_LOGIC_OR:  assert (op != 2'd1 || result == (ea | eb));              // R2
            AST_SUM_CARRY: assert (op != 2'd2 || {carry_out, result} == full);      // R3
            AST_SLT_UPPER: assert (op != 2'd3 || result[W-1:1] == '0);              // R6
            AST_SLT_SIGNED: assert (op != 2'd3 || inv_a || !inv_b
                                    || result[0] == ($signed(a) < $signed(b)));     // R6
            AST_OVERFLOW: assert (overflow ==
                                  ((ea[W-1] == eb[W-1]) && (full[W-1] != ea[W-1]))); // R7
        end
    end
endmodule

bind alu_bitslice alu_bitslice_chk #(.W(W)) u_chk (.*);

// File: tb/test_alu_bitslice.sv
module test_alu_bitslice;
    localparam int  W      = 32;
    localparam time CLK_P  = 10ns;
    localparam int  NRAND  = 150;

    typedef struct {
        logic [3:0]   ctl;
        logic [W-1:0] res;
        logic         zero;
        logic         ovf;
        logic         cout;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic         inv_a = 1'b0, inv_b = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [W-1:0] result;
    logic         zero, overflow, carry_out;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   drive_done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    alu_bitslice #(.W(W)) i_alu_bitslice (
        .a(a), .b(b), .inv_a(inv_a), .inv_b(inv_b), .op(op),
        .result(result), .zero(zero), .overflow(overflow), .carry_out(carry_out)
    );

    function automatic exp_t model(logic [3:0] ctl, logic [W-1:0] x, logic [W-1:0] y);
        exp_t e;
        logic [W-1:0] xe, ye;
        logic [W:0]   s;
        logic         sv, st;
        xe = ctl[3] ? ~x : x;
        ye = ctl[2] ? ~y : y;
        s  = {1'b0, xe} + {1'b0, ye} + (W+1)'(ctl[2]);
        sv = (xe[W-1] == ye[W-1]) && (s[W-1] != xe[W-1]);
        st = s[W-1] ^ sv;
        case (ctl[1:0])
            2'd0: e.res = xe & ye;
            2'd1: e.res = xe | ye;
            2'd2: e.res = s[W-1:0];
            default: e.res = {{(W-1){1'b0}}, st};
        endcase
        e.ctl  = ctl;
        e.zero = (e.res == '0);
        e.ovf  = sv;
        e.cout = s[W];
        return e;
    endfunction

    function automatic string res_tag(logic [3:0] ctl);
        case (ctl)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] ctl, logic [W-1:0] x, logic [W-1:0] y);
        @(posedge clk);
        #1;
        {inv_a, inv_b, op} = ctl;
        a = x;
        b = y;
        exp_q.push_back(model(ctl, x, y));
    endtask

    // monitor: compares half a cycle after each drive
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(res_tag(e.ctl), "result", result, e.res);
                check("R8", "zero", W'(zero), W'(e.zero));
                check("R7", "overflow", W'(overflow), W'(e.ovf));
                if (e.ctl == 4'b0010)
                    check("R3", "carry_out", W'(carry_out), W'(e.cout));
                else if (e.ctl == 4'b0110)
                    check("R4", "carry_out", W'(carry_out), W'(e.cout));
            end
        end
    end

    initial begin
        logic [3:0]   codes [8] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110,
                                    4'b0111, 4'b1100, 4'b1010, 4'b0011};
        logic [W-1:0] edge_v [4] = '{32'h0000_0000, 32'hFFFF_FFFF,
                                     32'h7FFF_FFFF, 32'h8000_0000};
        repeat (3) @(posedge clk);
        #1;
        // state after reset, all inputs zero: AND of zeros
        check("R8", "reset zero", W'(zero), W'(1'b1));
        check("R1", "reset result", result, '0);
        rst_n = 1'b1;
        // R3 full-length carry ripple
        drive(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);
        // R4 equal operands give zero, no borrow
        drive(4'b0110, 32'h1234_5678, 32'h1234_5678);
        // R6 overflowing compares
        drive(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
        drive(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
        // R5 NOR of zeros is all ones
        drive(4'b1100, 32'h0, 32'h0);
        for (int c = 0; c < 8; c++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    drive(codes[c], edge_v[i], edge_v[j]);
        for (int c = 0; c < 8; c++)
            for (int n = 0; n < NRAND; n++)
                drive(codes[c], $urandom(), (n % 5 == 0) ? 32'($urandom() % 4) : $urandom());
        @(posedge clk);
        @(posedge clk);
        drive_done = 1'b1;
    end

    initial begin
        fork
            wait (drive_done && exp_q.size() == 0);
            begin
                repeat (100000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule